// File: doc/BRIEF.md
# Clocked Synchronous Byte Transceiver

This block moves bytes over a two-wire link made of a serial clock line and a serial data line. There is no start, stop or acknowledge framing: each byte is exactly eight clock periods. The port either generates the clock itself (master) or follows a clock from the far end (slave). A direction bit selects transmit or receive. A 4-bit select sets the length of each clock half period in system clock cycles.

On the transmit side, a holding register sits in front of a shift register. A transmit-empty flag tells the host when the next byte can be written. On the receive side, a shift register feeds a holding register. A receive-full flag marks a new byte, and an overrun flag records a byte that arrived while the previous one was still unread. As clock master in receive mode, the port keeps the clock running byte after byte. A stop request lets the byte in flight finish and then leaves the clock parked high. Bits go most significant first unless a configuration bit selects least significant first.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `tx_empty` is 1, `rx_full` is 0 and `overrun` is 0. With `cfg_en` low, `sclk_oe` and `sda_oe` are 0.
- R2: `sclk_oe` is 1 exactly when `cfg_en` and `cfg_master` are both 1. `sda_oe` is 1 exactly when `cfg_en` and `cfg_tx` are both 1.
- R3: As master, every clock half period lasts `cfg_clk_sel`+1 system clock cycles.
- R4: In receive mode, `sda_i` is sampled on each rising clock edge. On the eighth rise, the assembled byte appears on `rd_data` and `rx_full` sets, in the same cycle. With `cfg_lsb_first`=0 the first bit received is bit 7; with `cfg_lsb_first`=1 it is bit 0.
- R5: A one-cycle `rd_strobe` pulse clears `rx_full`.
- R6: As master in receive mode with `rx_stop` low, bytes follow one another with no gap: the 24th rise comes 47 half periods after the first fall.
- R7: If the eighth rise of a byte arrives while `rx_full` is 1, `overrun` sets, `rd_data` keeps the older byte and the new byte is dropped. A one-cycle `ovr_clr` pulse clears `overrun`.
- R8: If `rx_stop` is 1 when a received byte completes, the master starts no further byte and holds `sclk_o` high. Setting `rx_stop` during a byte therefore yields exactly one more byte.
- R9: A `wr_vld` pulse while `tx_empty` is 1 captures `wr_data` and clears `tx_empty`. A write while `tx_empty` is 0 is ignored.
- R10: In transmit mode, the falling edge that starts a byte moves the holding register into the shift register and sets `tx_empty`. `sda_o` changes only on falling edges. Bit order follows `cfg_lsb_first` as in R4.
- R11: If the next byte is written before the current one ends, the master sends it with no gap: the 16th rise comes 31 half periods after the first fall.
- R12: As master, when no byte is waiting to be transmitted at a byte boundary, `sclk_o` stays high and no edge occurs.
- R13: As slave, edges on `sclk_i` (passed through a two-stage synchronizer) drive the same shifting, sampling and flag behaviour, and `sclk_o` is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1: generate the serial clock; 0: follow `sclk_i` |
| cfg_tx | input | 1 | 1: transmit; 0: receive |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_clk_sel | input | 4 | Half period length minus one, in system cycles |
| rx_stop | input | 1 | Receive stop request (master receive) |
| wr_vld | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_strobe | input | 1 | Read strobe for the receive holding register |
| rd_data | output | 8 | Receive holding register |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| overrun | output | 1 | A byte was dropped because the last one was unread |
| sclk_i | input | 1 | Serial clock from the line |
| sclk_o | output | 1 | Serial clock to the line |
| sclk_oe | output | 1 | Output enable for `sclk_o` |
| sda_i | input | 1 | Serial data from the line |
| sda_o | output | 1 | Serial data to the line |
| sda_oe | output | 1 | Output enable for `sda_o` |

## Verification
Serial clock edges appear one register after the tick that causes them. The bench time-stamps every edge of `sclk_o` one nanosecond after the system edge. It checks that spans between edges are exact multiples of `cfg_clk_sel`+1 cycles. `rx_full`, `rd_data` and `overrun` change in the cycle of the eighth rise, and `tx_empty` changes in the cycle of a byte's first fall. The bench therefore waits on these flags at falling system-clock edges, never on a fixed count. A strobe clears its flag in the next cycle, and that flag is checked at the next falling edge. Slave traffic goes through the two-stage synchronizer, so the bench holds each `sclk_i` level for four cycles before it samples `sda_o` or the flags.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 8;
  localparam int CW = $clog2(DW);
  typedef logic [DW-1:0] byte_t;
  typedef logic [CW-1:0] cnt_t;

  // Bit that leaves the shift register next.
  function automatic logic out_bit(byte_t s, logic lsb);
    return lsb ? s[0] : s[DW-1];
  endfunction

  // Shift register after one bit has left.
  function automatic byte_t shift_out(byte_t s, logic lsb);
    return lsb ? {1'b0, s[DW-1:1]} : {s[DW-2:0], 1'b0};
  endfunction

  // Shift register after one bit has arrived.
  function automatic byte_t shift_in(byte_t s, logic b, logic lsb);
    return lsb ? {b, s[DW-1:1]} : {s[DW-2:0], b};
  endfunction

  // Bit position after a rising edge, wrapping at the byte length.
  function automatic cnt_t bit_next(cnt_t c);
    return (c == cnt_t'(DW - 1)) ? '0 : c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/ssp_tick_gen.sv
module ssp_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= sel);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && (sel != '0) |=> !tick);
endmodule

// File: rtl/ssp_clk_engine.sv
module ssp_clk_engine
  import ssp_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic [DIV_W-1:0] sel,
  input  logic             start_ok,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             first_fall,
  output logic             byte_done
);
  logic       sclk_q;
  cnt_t       bitcnt;
  logic       mid_byte, m_act, s_act, run, tick;
  logic       m_fall, m_rise, s_fall, s_rise;
  logic [2:0] s_sync;

  assign m_act    = en && master;
  assign s_act    = en && !master;
  assign mid_byte = (bitcnt != '0);
  assign run      = m_act && (!sclk_q || mid_byte || start_ok);

  ssp_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
  );

  assign m_fall = tick && sclk_q;
  assign m_rise = tick && !sclk_q;
  assign s_rise = s_sync[1] && !s_sync[2];
  assign s_fall = !s_sync[1] && s_sync[2];

  assign fall_ev    = m_fall || (s_act && s_fall);
  assign rise_ev    = m_rise || (s_act && s_rise);
  assign first_fall = fall_ev && !mid_byte;
  assign byte_done  = rise_ev && (bitcnt == cnt_t'(DW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      bitcnt <= '0;
      s_sync <= 3'b111;
    end else begin
      s_sync <= {s_sync[1:0], sclk_i};
      if (!m_act)    sclk_q <= 1'b1;
      else if (tick) sclk_q <= !sclk_q;
      if (!en)          bitcnt <= '0;
      else if (rise_ev) bitcnt <= bit_next(bitcnt);
    end
  end

  assign sclk_o  = sclk_q;
  assign sclk_oe = m_act;

  // Parked clock stays high while nothing may start (R8, R12).
  p_blocked_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    m_act && sclk_q && !mid_byte && !start_ok |=> sclk_q);
  // A slave never drives the clock line.
  p_slave_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    s_act |-> !sclk_oe && sclk_o);
endmodule

// File: rtl/ssp_buffers.sv
module ssp_buffers
  import ssp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tx_mode,
  input  logic  lsb_first,
  input  logic  fall_ev,
  input  logic  rise_ev,
  input  logic  first_fall,
  input  logic  byte_done,
  input  logic  sda_i,
  input  logic  wr_vld,
  input  byte_t wr_data,
  input  logic  rd_strobe,
  input  logic  ovr_clr,
  output byte_t rd_data,
  output logic  tx_empty,
  output logic  rx_full,
  output logic  overrun,
  output logic  sda_o,
  output logic  sda_oe
);
  byte_t tx_hold, shreg, rx_hold, rx_next;
  logic  load_ev, wr_take, rx_done;

  assign rx_next = shift_in(shreg, sda_i, lsb_first);
  assign load_ev = tx_mode && first_fall;
  assign wr_take = wr_vld && tx_empty;
  assign rx_done = !tx_mode && byte_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      shreg    <= '0;
      rx_hold  <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wr_take) begin
        tx_hold  <= wr_data;
        tx_empty <= 1'b0;
      end else if (load_ev) begin
        tx_empty <= 1'b1;
      end

      if (tx_mode) begin
        if (load_ev)      shreg <= tx_hold;
        else if (fall_ev) shreg <= shift_out(shreg, lsb_first);
      end else if (rise_ev) begin
        shreg <= rx_next;
      end

      if (rx_done && !rx_full) begin
        rx_hold <= rx_next;
        rx_full <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end

      if (rx_done && rx_full) overrun <= 1'b1;
      else if (ovr_clr)       overrun <= 1'b0;
    end
  end

  assign rd_data = rx_hold;
  assign sda_o   = out_bit(shreg, lsb_first);
  assign sda_oe  = en && tx_mode;

  p_rx_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_full |=> rx_full && (rd_data == $past(rx_next)));
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !rx_done |=> !rx_full);
  p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full |=> overrun && $stable(rd_data));
  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && !tx_empty |=> $stable(tx_hold));
  p_load_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev && !wr_vld |=> tx_empty);
  p_data_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode && !fall_ev && !wr_vld && !rd_strobe |=> $stable(sda_o));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_master,
  input  logic             cfg_tx,
  input  logic             cfg_lsb_first,
  input  logic [DIV_W-1:0] cfg_clk_sel,
  input  logic             rx_stop,
  input  logic             wr_vld,
  input  logic [7:0]       wr_data,
  input  logic             rd_strobe,
  output logic [7:0]       rd_data,
  input  logic             ovr_clr,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             overrun,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sda_i,
  output logic             sda_o,
  output logic             sda_oe
);
  logic start_ok, fall_ev, rise_ev, first_fall, byte_done;

  // A new byte may begin when data waits to go out, or, when receiving, no stop is requested.
  assign start_ok = cfg_tx ? !tx_empty : !rx_stop;

  ssp_clk_engine #(.DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .master(cfg_master),
    .sel(cfg_clk_sel), .start_ok(start_ok), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .fall_ev(fall_ev),
    .rise_ev(rise_ev), .first_fall(first_fall), .byte_done(byte_done)
  );

  ssp_buffers u_buffers (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .tx_mode(cfg_tx),
    .lsb_first(cfg_lsb_first), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .first_fall(first_fall), .byte_done(byte_done), .sda_i(sda_i),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .ovr_clr(ovr_clr), .rd_data(rd_data), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  p_stop_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && cfg_master && !cfg_tx && rx_stop && byte_done |=> sclk_o);
endmodule

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 0, cfg_master = 0, cfg_tx = 0, cfg_lsb_first = 0;
  logic [3:0] cfg_clk_sel = '0;
  logic       rx_stop = 0, wr_vld = 0, rd_strobe = 0, ovr_clr = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_empty, rx_full, overrun;
  logic       sclk_i = 1'b1, sda_i = 1'b0;
  logic       sclk_o, sclk_oe, sda_o, sda_oe;

  always #2.5 clk = ~clk;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_tx(cfg_tx), .cfg_lsb_first(cfg_lsb_first), .cfg_clk_sel(cfg_clk_sel),
    .rx_stop(rx_stop), .wr_vld(wr_vld), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .ovr_clr(ovr_clr),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sda_i(sda_i), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  int nvec = 0, nerr = 0;
  bit summary_done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    end
    $finish;
  endtask

  // Line monitor: time-stamps serial clock edges 1 ns after each system edge.
  logic       mon_rst = 1'b1, prev_sc = 1'b1;
  int         rises = 0, falls = 0, cyc = 0, first_fall_cyc = 0, last_rise_cyc = 0;
  logic [7:0] shcap = '0;
  logic [7:0] cap_q [0:7];
  logic [7:0] rx_pat [0:3];

  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (mon_rst) begin
      rises = 0; falls = 0; prev_sc = 1'b1;
    end else begin
      if (sclk_o && !prev_sc) begin
        rises++;
        last_rise_cyc = cyc;
        shcap = cfg_lsb_first ? {sda_o, shcap[7:1]} : {shcap[6:0], sda_o};
        if ((rises % 8 == 0) && (rises / 8 <= 8)) cap_q[rises/8 - 1] = shcap;
      end
      if (!sclk_o && prev_sc) begin
        falls++;
        if (falls == 1) first_fall_cyc = cyc;
        if (!cfg_tx && ((falls - 1) / 8 < 4)) begin
          automatic int idx = (falls - 1) / 8;
          automatic int k = (falls - 1) % 8;
          sda_i = cfg_lsb_first ? rx_pat[idx][k] : rx_pat[idx][7-k];
        end
      end
      prev_sc = sclk_o;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mon_rst = 1;
    cfg_en = 0; cfg_master = 0; cfg_tx = 0; cfg_lsb_first = 0; cfg_clk_sel = '0;
    rx_stop = 0; wr_vld = 0; rd_strobe = 0; ovr_clr = 0; sclk_i = 1; sda_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; mon_rst = 0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_vld = 1; wr_data = d;
    @(negedge clk); wr_vld = 0;
  endtask

  task automatic read_byte();
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
  endtask

  task automatic wait_full();
    while (!rx_full) @(negedge clk);
  endtask

  task automatic slave_half(input logic lvl);
    sclk_i = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int sels [4] = '{0, 1, 2, 5};
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 sclk_o", 32'(sclk_o), 1);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 rx_full", 32'(rx_full), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 sclk_oe", 32'(sclk_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);

    // R2: output enables; R12: idle master with nothing to send
    cfg_en = 1; cfg_master = 1; cfg_tx = 1;
    @(negedge clk);
    chk("R2 sclk_oe master", 32'(sclk_oe), 1);
    chk("R2 sda_oe tx", 32'(sda_oe), 1);
    repeat (20) @(negedge clk);
    chk("R12 no edges while empty", 32'(rises + falls), 0);
    chk("R12 clock high", 32'(sclk_o), 1);
    cfg_master = 0; cfg_tx = 0;
    @(negedge clk);
    chk("R2 sclk_oe slave", 32'(sclk_oe), 0);
    chk("R2 sda_oe rx", 32'(sda_oe), 0);

    // Transmit sweep: R3, R9, R10, R11, R12
    for (int si = 0; si < 4; si++) begin
      for (int lb = 0; lb < 2; lb++) begin
        automatic int h = sels[si] + 1;
        automatic logic [7:0] a = 8'(8'h5A + si * 37 + lb * 11);
        automatic logic [7:0] b = 8'(~a ^ 8'h36);
        automatic logic [7:0] c = 8'(a + 8'h71);
        do_reset();
        cfg_clk_sel = 4'(sels[si]); cfg_lsb_first = 1'(lb);
        cfg_en = 1; cfg_master = 1; cfg_tx = 1;
        write_byte(a);
        chk("R9 write clears empty", 32'(tx_empty), 0);
        while (!tx_empty) @(negedge clk);
        chk("R10 empty after load", 32'(tx_empty), 1);
        write_byte(b);
        write_byte(c); // ignored: holding register full (R9)
        while (rises < 16) @(negedge clk);
        repeat (4 * h + 8) @(negedge clk);
        chk("R10 first byte", 32'(cap_q[0]), 32'(a));
        chk("R9 second byte kept", 32'(cap_q[1]), 32'(b));
        chk("R11 back-to-back span", 32'(last_rise_cyc - first_fall_cyc), 32'(31 * h));
        chk("R12 stops after data", 32'(rises), 16);
        chk("R12 parked high", 32'(sclk_o), 1);
        chk("R3 fall count", 32'(falls), 16);
      end
    end

    // Receive sweep: R4, R5, R6, R8
    for (int si = 0; si < 2; si++) begin
      for (int lb = 0; lb < 2; lb++) begin
        automatic int h = 2 * si + 1;
        do_reset();
        rx_pat[0] = 8'(8'hC3 + si * 5 + lb);
        rx_pat[1] = 8'(8'h1E ^ (si * 64 + lb * 8));
        rx_pat[2] = 8'(8'hB4 - lb * 3);
        rx_pat[3] = 8'h77;
        cfg_clk_sel = 4'(2 * si); cfg_lsb_first = 1'(lb);
        cfg_en = 1; cfg_master = 1; cfg_tx = 0;
        wait_full();
        chk("R4 byte 0", 32'(rd_data), 32'(rx_pat[0]));
        read_byte();
        chk("R5 read clears full", 32'(rx_full), 0);
        wait_full();
        while (falls <= 16) @(negedge clk);
        rx_stop = 1;
        chk("R4 byte 1", 32'(rd_data), 32'(rx_pat[1]));
        read_byte();
        wait_full();
        chk("R8 last byte", 32'(rd_data), 32'(rx_pat[2]));
        read_byte();
        repeat (30 * h + 10) @(negedge clk);
        chk("R8 exactly one more byte", 32'(rises), 24);
        chk("R8 clock parked", 32'(sclk_o), 1);
        chk("R6 continuous span", 32'(last_rise_cyc - first_fall_cyc), 32'(47 * h));
        chk("R6 no overrun", 32'(overrun), 0);
        chk("R5 full clear at end", 32'(rx_full), 0);
      end
    end

    // Overrun: R7
    do_reset();
    rx_pat[0] = 8'h96; rx_pat[1] = 8'h2D; rx_pat[2] = 8'hE1; rx_pat[3] = 8'h48;
    cfg_clk_sel = 4'd1; cfg_en = 1; cfg_master = 1; cfg_tx = 0;
    while (rises < 16) @(negedge clk);
    @(negedge clk);
    chk("R7 overrun set", 32'(overrun), 1);
    chk("R7 old byte kept", 32'(rd_data), 32'h96);
    chk("R7 still full", 32'(rx_full), 1);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk("R7 overrun cleared", 32'(overrun), 0);
    while (falls <= 16) @(negedge clk);
    rx_stop = 1;
    read_byte();
    wait_full();
    chk("R7 later byte after drop", 32'(rd_data), 32'hE1);
    repeat (40) @(negedge clk);
    chk("R8 stop after overrun", 32'(rises), 24);

    // Slave receive then transmit: R13
    do_reset();
    cfg_en = 1; cfg_master = 0; cfg_tx = 0;
    for (int k = 7; k >= 0; k--) begin
      sda_i = 8'h3C >> k;
      slave_half(1'b0);
      slave_half(1'b1);
    end
    chk("R13 slave rx full", 32'(rx_full), 1);
    chk("R13 slave rx data", 32'(rd_data), 32'h3C);
    chk("R13 slave clock not driven", 32'(sclk_oe), 0);
    read_byte();
    cfg_tx = 1;
    write_byte(8'hC6);
    begin
      automatic logic [7:0] got = '0;
      for (int k = 0; k < 8; k++) begin
        slave_half(1'b0);
        got = {got[6:0], sda_o};
        slave_half(1'b1);
      end
      chk("R13 slave tx data", 32'(got), 32'hC6);
    end
    chk("R13 slave tx empty", 32'(tx_empty), 1);
    chk("R13 no receive in tx", 32'(rx_full), 0);

    summary();
  end
endmodule